// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a direct-mapped instruction or data cache and soaks up compulsory and capacity misses on sequential code or data. It keeps a short FIFO of line addresses that directly follow the most recent unserved miss, and it fetches those lines from the next memory level ahead of demand. The missing line itself is fetched into the cache by the cache's own refill path. This buffer only ever holds the lines that come after it.

The cache presents each miss on a valid/ready channel. Only the oldest entry of the FIFO, its head, is compared with that line address. If the head matches and its data has arrived, the block answers with a hit and the line data. It then drops the head and queues one more sequential line at the tail. If the head matches but the data is still in flight, the answer waits for the data. If the head does not match, the block answers with a miss, discards the whole FIFO and starts a new stream at the following line.

Memory requests go out on a valid/ready channel and carry a stream generation tag. Memory responses return that tag and are always accepted. Back-pressure rules are as follows:
- A request holds its line and tag stable until it is taken.
- A response to the cache holds its hit flag and data stable until `rsp_ready`.
- No new miss is accepted (`miss_ready` low) while a miss is being resolved or its response is still waiting.

Top module: `sb_prefetch`

## Requirements
- R1: Out of reset `miss_ready` is 1 and `rsp_valid` and `mreq_valid` are 0. The buffer starts empty, so the first miss is answered with `rsp_hit` = 0.
- R2: When a miss line differs from the head line, or the buffer is empty, `rsp_valid` rises one cycle after the miss is accepted, with `rsp_hit` = 0. The stream restarts on lines miss+1 to miss+DEPTH, counted modulo 2^LINE_AW, and the first request of the new stream is for miss+1.
- R3: A miss whose line is held in the buffer at any position other than the head is answered as a miss (`rsp_hit` = 0) and restarts the stream from that line.
- R4: When the miss line equals the head line and the head data has arrived, `rsp_valid` rises one cycle after acceptance with `rsp_hit` = 1 and `rsp_data` equal to the data memory returned for that line.
- R5: When the miss line equals the head line but the data has not yet arrived, no response is given. The hit response is registered on the same clock edge that accepts that line's memory data, and it carries that data.
- R6: Each head hit removes the head and appends the next line after the current tail. A stream that has served N hits therefore issues exactly DEPTH+N requests.
- R7: Within one stream generation, memory requests go out in strictly ascending consecutive line order, each line at most once. `mreq_line` and `mreq_gen` stay stable while `mreq_valid` is high and `mreq_ready` is low.
- R8: A memory response whose `mrsp_gen` differs from the current stream generation is dropped and never reaches the cache.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_hit` and `rsp_data` hold, and `miss_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss request valid |
| miss_ready | output | 1 | Block can accept a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| rsp_valid | output | 1 | Answer to the cache valid |
| rsp_ready | input | 1 | Cache takes the answer |
| rsp_hit | output | 1 | 1: buffer supplies the line; 0: not in buffer |
| rsp_data | output | DATA_W | Line data on a hit, zero on a miss |
| mreq_valid | output | 1 | Line fetch request valid |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_line | output | LINE_AW | Line address to fetch |
| mreq_gen | output | GEN_W | Stream generation of the request |
| mrsp_valid | input | 1 | Memory data return valid (always accepted) |
| mrsp_line | input | LINE_AW | Line address of the returned data |
| mrsp_gen | input | GEN_W | Generation copied from the request |
| mrsp_data | input | DATA_W | Returned line data |

## Verification
A miss answer and a hit on already-arrived data are both due on the second falling edge after the accepting rising edge, so the bench counts falling edges from acceptance and expects exactly two. For a stalled hit, the bench notes the cycle in which its memory model presented that line's data. It then expects the answer on the very next falling edge, one rising edge later. Requests are logged on the falling edge before the rising edge that takes them, so ordering and per-stream request counts are checked against that log after a settling wait. Held-response behaviour is sampled on every falling edge while `rsp_ready` is low.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Per-entry state bits of the stream FIFO
  typedef struct packed {
    logic vld;   // entry holds a line address of the current stream
    logic req;   // fetch for this line has been issued
    logic avl;   // line data has arrived
  } sb_flags_t;

  localparam sb_flags_t SB_FRESH = '{vld: 1'b1, req: 1'b0, avl: 1'b0};
endpackage

// File: rtl/sb_tag_cmp.sv
module sb_tag_cmp #(
  parameter int DEPTH = 8,
  parameter int AW    = 26
) (
  input  logic [DEPTH-1:0][AW-1:0] tags,
  input  logic [DEPTH-1:0]         qual,
  input  logic [AW-1:0]            key,
  output logic [DEPTH-1:0]         hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = qual[g] && (tags[g] == key);
  end
endmodule

// File: rtl/sb_first_set.sv
module sb_first_set #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sb_line_queue.sv
module sb_line_queue
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 26,
  parameter int DW    = 64,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] restart_base,
  input  logic          shift,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_line,
  input  logic [DW-1:0] fill_data,
  input  logic          mark_en,
  input  logic [IW-1:0] mark_idx,
  output logic          head_vld,
  output logic [AW-1:0] head_tag,
  output logic          head_avl,
  output logic          head_fill,
  output logic [DW-1:0] head_data,
  output logic          pick_any,
  output logic [IW-1:0] pick_idx,
  output logic [AW-1:0] pick_tag
);
  localparam int LAST = DEPTH - 1;

  sb_flags_t [DEPTH-1:0]         flg_q, flg_n;
  logic      [DEPTH-1:0][AW-1:0] tag_q, tag_n;
  logic      [DEPTH-1:0][DW-1:0] dat_q, dat_n;
  logic      [AW-1:0]            tail_q, tail_n;

  logic [DEPTH-1:0] fill_qual, fill_cmp, fill_hit, pending;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign fill_qual[g] = flg_q[g].vld && flg_q[g].req && !flg_q[g].avl;
    assign pending[g]   = flg_q[g].vld && !flg_q[g].req;
  end

  sb_tag_cmp #(.DEPTH(DEPTH), .AW(AW)) u_fill_cmp (
    .tags (tag_q),
    .qual (fill_qual),
    .key  (fill_line),
    .hit  (fill_cmp)
  );

  assign fill_hit = fill_cmp & {DEPTH{fill_en}};

  sb_first_set #(.N(DEPTH), .IW(IW)) u_pick (
    .vec (pending),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign pick_tag  = tag_q[pick_idx];
  assign head_vld  = flg_q[0].vld;
  assign head_tag  = tag_q[0];
  assign head_avl  = flg_q[0].avl;
  assign head_fill = fill_hit[0];
  assign head_data = dat_q[0];

  // Order of effects: data fill, issue mark, head removal, stream restart
  always_comb begin
    flg_n  = flg_q;
    tag_n  = tag_q;
    dat_n  = dat_q;
    tail_n = tail_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (fill_hit[i]) begin
        flg_n[i].avl = 1'b1;
        dat_n[i]     = fill_data;
      end
    end
    if (mark_en) flg_n[mark_idx].req = 1'b1;
    if (shift) begin
      for (int i = 0; i < LAST; i++) begin
        flg_n[i] = flg_n[i+1];
        tag_n[i] = tag_n[i+1];
        dat_n[i] = dat_n[i+1];
      end
      flg_n[LAST] = SB_FRESH;
      tag_n[LAST] = tail_q;
      dat_n[LAST] = '0;
      tail_n      = tail_q + AW'(1);
    end
    if (restart) begin
      for (int i = 0; i < DEPTH; i++) begin
        flg_n[i] = SB_FRESH;
        tag_n[i] = restart_base + AW'(i);
      end
      tail_n = restart_base + AW'(DEPTH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q  <= '0;
      tag_q  <= '0;
      dat_q  <= '0;
      tail_q <= '0;
    end else begin
      flg_q  <= flg_n;
      tag_q  <= tag_n;
      dat_q  <= dat_n;
      tail_q <= tail_n;
    end
  end
endmodule

// File: rtl/sb_prefetch.sv
module sb_prefetch #(
  parameter int DEPTH   = 8,
  parameter int LINE_AW = 26,
  parameter int DATA_W  = 64,
  parameter int GEN_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               mreq_valid,
  input  logic               mreq_ready,
  output logic [LINE_AW-1:0] mreq_line,
  output logic [GEN_W-1:0]   mreq_gen,
  input  logic               mrsp_valid,
  input  logic [LINE_AW-1:0] mrsp_line,
  input  logic [GEN_W-1:0]   mrsp_gen,
  input  logic [DATA_W-1:0]  mrsp_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               cur_v;
  logic [LINE_AW-1:0] cur_line;
  logic [GEN_W-1:0]   gen_q;
  logic               rsp_v_q, rsp_hit_q;
  logic [DATA_W-1:0]  rsp_data_q;
  logic               mreq_v_q;
  logic [LINE_AW-1:0] mreq_line_q;
  logic [GEN_W-1:0]   mreq_gen_q;

  logic               head_vld, head_avl, head_fill;
  logic [LINE_AW-1:0] head_tag;
  logic [DATA_W-1:0]  head_data;
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  logic [LINE_AW-1:0] pick_tag;

  logic accept, head_match, hit_go, miss_go, fill_en, can_load, load;

  assign miss_ready = !cur_v && !rsp_v_q;
  assign accept     = miss_valid && miss_ready;
  assign head_match = cur_v && head_vld && (head_tag == cur_line);
  assign hit_go     = head_match && (head_avl || head_fill);
  assign miss_go    = cur_v && !head_match;
  assign fill_en    = mrsp_valid && (mrsp_gen == gen_q);
  assign can_load   = !mreq_v_q || mreq_ready;
  assign load       = can_load && pick_any && !miss_go;

  sb_line_queue #(.DEPTH(DEPTH), .AW(LINE_AW), .DW(DATA_W), .IW(IW)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (miss_go),
    .restart_base (cur_line + LINE_AW'(1)),
    .shift        (hit_go),
    .fill_en      (fill_en),
    .fill_line    (mrsp_line),
    .fill_data    (mrsp_data),
    .mark_en      (load),
    .mark_idx     (pick_idx),
    .head_vld     (head_vld),
    .head_tag     (head_tag),
    .head_avl     (head_avl),
    .head_fill    (head_fill),
    .head_data    (head_data),
    .pick_any     (pick_any),
    .pick_idx     (pick_idx),
    .pick_tag     (pick_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v      <= 1'b0;
      cur_line   <= '0;
      gen_q      <= '0;
      rsp_v_q    <= 1'b0;
      rsp_hit_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      if (accept) begin
        cur_v    <= 1'b1;
        cur_line <= miss_line;
      end else if (hit_go || miss_go) begin
        cur_v <= 1'b0;
      end
      if (miss_go) gen_q <= gen_q + GEN_W'(1);
      if (hit_go || miss_go) begin
        rsp_v_q    <= 1'b1;
        rsp_hit_q  <= hit_go;
        rsp_data_q <= !hit_go ? '0 : (head_avl ? head_data : mrsp_data);
      end else if (rsp_ready) begin
        rsp_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mreq_v_q    <= 1'b0;
      mreq_line_q <= '0;
      mreq_gen_q  <= '0;
    end else if (can_load) begin
      mreq_v_q <= load;
      if (load) begin
        mreq_line_q <= pick_tag;
        mreq_gen_q  <= gen_q;
      end
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_data   = rsp_data_q;
  assign mreq_valid = mreq_v_q;
  assign mreq_line  = mreq_line_q;
  assign mreq_gen   = mreq_gen_q;
endmodule

// File: rtl/sb_prefetch_chk.sv
module sb_prefetch_chk #(
  parameter int AW = 26,
  parameter int DW = 64,
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_hit,
  input logic [DW-1:0] rsp_data,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic [AW-1:0] mreq_line,
  input logic [GW-1:0] mreq_gen,
  input logic [GW-1:0] gen_q
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_data));

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !miss_ready);

  // R7
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_line) && $stable(mreq_gen));

  // R7
  mreq_gen_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreq_valid) |-> mreq_gen == gen_q);

  // R2
  miss_new_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_hit |-> gen_q != $past(gen_q));

  // R4
  hit_same_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_hit |-> gen_q == $past(gen_q));
endmodule

bind sb_prefetch sb_prefetch_chk #(.AW(LINE_AW), .DW(DATA_W), .GW(GEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_ready (miss_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_hit    (rsp_hit),
  .rsp_data   (rsp_data),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_line  (mreq_line),
  .mreq_gen   (mreq_gen),
  .gen_q      (gen_q)
);

// File: tb/sb_prefetch_test.sv
`timescale 1ns/1ps
module sb_prefetch_test;
  localparam int D  = 4;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int GW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_line = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          mreq_valid;
  logic          mreq_ready = 1'b0;
  logic [AW-1:0] mreq_line;
  logic [GW-1:0] mreq_gen;
  logic          mrsp_valid = 1'b0;
  logic [AW-1:0] mrsp_line = '0;
  logic [GW-1:0] mrsp_gen = '0;
  logic [DW-1:0] mrsp_data = '0;

  always #5 clk = ~clk;

  sb_prefetch #(.DEPTH(D), .LINE_AW(AW), .DATA_W(DW), .GEN_W(GW)) uut (.*);

  int errs = 0, chks = 0, pcyc = 0;
  bit done = 1'b0;
  always @(posedge clk) pcyc++;

  function automatic logic [DW-1:0] dfun(logic [AW-1:0] a);
    return {a, ~a, 8'h5A};
  endfunction

  function automatic logic [AW-1:0] addl(logic [AW-1:0] a, int k);
    return a + AW'(k);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model state
  logic [AW-1:0] q_line[64];
  logic [GW-1:0] q_gen[64];
  int q_rd = 0, q_wr = 0;
  bit mem_en = 1'b1;
  int rdy_mode = 0;
  bit inj_v = 1'b0;
  logic [AW-1:0] inj_line;
  logic [GW-1:0] inj_gen;
  logic [DW-1:0] inj_data;
  bit watch_en = 1'b0;
  logic [AW-1:0] watch_line;
  int watch_cyc = -1;
  logic [AW-1:0] lg_line[2048];
  logic [GW-1:0] lg_gen[2048];
  int lg_n = 0;

  always @(negedge clk) begin
    logic [AW-1:0] nx;
    if (!rst_n) begin
      mrsp_valid = 1'b0;
      mreq_ready = 1'b0;
    end else begin
      if (inj_v) begin
        mrsp_valid = 1'b1; mrsp_line = inj_line; mrsp_gen = inj_gen; mrsp_data = inj_data;
        inj_v = 1'b0;
      end else if (mem_en && q_rd != q_wr) begin
        mrsp_valid = 1'b1;
        mrsp_line  = q_line[q_rd % 64];
        mrsp_gen   = q_gen[q_rd % 64];
        mrsp_data  = dfun(mrsp_line);
        if (watch_en && mrsp_line == watch_line) watch_cyc = pcyc;
        q_rd++;
      end else begin
        mrsp_valid = 1'b0;
      end
      mreq_ready = (rdy_mode == 0) || ((pcyc % 2) == 0);
      if (mreq_valid && mreq_ready) begin
        if (lg_n > 0 && lg_gen[lg_n-1] == mreq_gen) begin
          nx = lg_line[lg_n-1] + 1'b1;
          chk(mreq_line == nx, "R7", "ascending request", 64'(mreq_line), 64'(nx));
        end
        lg_line[lg_n] = mreq_line;
        lg_gen[lg_n]  = mreq_gen;
        lg_n++;
        q_line[q_wr % 64] = mreq_line;
        q_gen[q_wr % 64]  = mreq_gen;
        q_wr++;
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_miss(logic [AW-1:0] a);
    @(posedge clk); #1;
    miss_valid = 1'b1;
    miss_line  = a;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic get_rsp(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_valid && lat < 300);
  endtask

  task automatic do_miss(logic [AW-1:0] a, bit exp_hit, string req);
    int lat;
    send_miss(a);
    get_rsp(lat);
    chk(rsp_valid, req, "response given", 64'(rsp_valid), 64'd1);
    chk(rsp_hit == exp_hit, req, "hit flag", 64'(rsp_hit), 64'(exp_hit));
    if (exp_hit) chk(rsp_data == dfun(a), req, "hit data", 64'(rsp_data), 64'(dfun(a)));
    chk(lat == 2, req, "response latency", 64'(lat), 64'd2);
  endtask

  initial begin
    logic [AW-1:0] bases[3];
    logic [GW-1:0] g, ga, gb;
    logic [DW-1:0] d0;
    int st, cnt, first, lat;
    bases[0] = 12'h010; bases[1] = 12'h7F0; bases[2] = 12'hFFD;

    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk(miss_ready == 1'b1, "R1", "miss_ready in reset", 64'(miss_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(mreq_valid == 1'b0, "R1", "mreq_valid in reset", 64'(mreq_valid), 64'd0);
    rst_n = 1'b1;
    wait_cyc(2);

    // R2 R4 R6 sweep over start lines, incl. address wrap
    for (int b = 0; b < 3; b++) begin
      rdy_mode = b % 2;
      do_miss(bases[b], 1'b0, (b == 0) ? "R1" : "R2");
      st = lg_n;
      wait_cyc(12);
      g = lg_gen[lg_n-1];
      first = -1;
      for (int i = lg_n - 1; i >= st; i--) if (lg_gen[i] == g) first = i;
      chk(first >= 0, "R2", "new stream issued", 64'(first), 64'(st));
      if (first >= 0)
        chk(lg_line[first] == addl(bases[b], 1), "R2", "first successor line",
            64'(lg_line[first]), 64'(addl(bases[b], 1)));
      for (int k = 1; k <= D + 2; k++) begin
        wait_cyc(12);
        do_miss(addl(bases[b], k), 1'b1, "R4");
      end
      wait_cyc(12);
      cnt = 0;
      for (int i = st; i < lg_n; i++) if (lg_gen[i] == g) cnt++;
      chk(cnt == 2 * D + 2, "R6", "requests per stream", 64'(cnt), 64'(2 * D + 2));
    end

    // R5 stalled head hit
    rdy_mode = 0;
    wait_cyc(1);
    mem_en = 1'b0;
    q_rd = q_wr;
    do_miss(12'h200, 1'b0, "R2");
    wait_cyc(8);
    send_miss(12'h201);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!rsp_valid, "R5", "no answer while data pending", 64'(rsp_valid), 64'd0);
    end
    @(posedge clk); #1;
    watch_line = 12'h201; watch_cyc = -1; watch_en = 1'b1;
    mem_en = 1'b1;
    get_rsp(lat);
    watch_en = 1'b0;
    chk(rsp_valid && rsp_hit, "R5", "stalled hit answered", 64'(rsp_hit), 64'd1);
    chk(rsp_data == dfun(12'h201), "R5", "stalled hit data", 64'(rsp_data), 64'(dfun(12'h201)));
    chk(pcyc == watch_cyc + 1, "R5", "answer edge vs data edge", 64'(pcyc), 64'(watch_cyc + 1));

    // R3 non-head line is a miss
    wait_cyc(12);
    do_miss(12'h203, 1'b0, "R3");
    wait_cyc(12);
    do_miss(12'h204, 1'b1, "R3");

    // R8 stale generation dropped
    wait_cyc(2);
    mem_en = 1'b0;
    q_rd = q_wr;
    do_miss(12'h300, 1'b0, "R8");
    wait_cyc(8);
    ga = lg_gen[lg_n-1];
    do_miss(12'h340, 1'b0, "R8");
    wait_cyc(8);
    gb = lg_gen[lg_n-1];
    chk(ga != gb, "R8", "generation changes on restart", 64'(gb), 64'(ga + 1'b1));
    inj_line = 12'h341; inj_gen = ga; inj_data = ~dfun(12'h341);
    inj_v = 1'b1;
    wait_cyc(3);
    mem_en = 1'b1;
    wait_cyc(12);
    do_miss(12'h341, 1'b1, "R8");

    // R9 response back-pressure
    wait_cyc(12);
    rsp_ready = 1'b0;
    send_miss(12'h342);
    get_rsp(lat);
    d0 = rsp_data;
    chk(rsp_hit && d0 == dfun(12'h342), "R9", "held hit data", 64'(d0), 64'(dfun(12'h342)));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_hit && rsp_data == d0, "R9", "response held", 64'(rsp_data), 64'(d0));
      chk(!miss_ready, "R9", "miss_ready low while held", 64'(miss_ready), 64'd0);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R9", "response released", 64'(rsp_valid), 64'd0);
    chk(miss_ready, "R9", "ready for next miss", 64'(miss_ready), 64'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule